// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is an I2C target that answers to one programmable 7-bit address. It watches the bus for start and stop conditions and collects the address byte. If the address matches, it acknowledges in hardware, holds SCL low and pulses an interrupt so that software can act. If the address does not match, it stays silent until the next start or stop.

In the read direction the stretch ends when software writes the next byte to transmit. That byte is then shifted out MSB first, and the controller's acknowledge decides whether to stretch again or to let go of the bus. In the write direction every received byte is acknowledged and stored, and the block then stretches until software pulses a release input. SCL and SDA are open-drain: each output enable, when high, pulls its line low.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, scl_oe, sda_oe, irq and busy are all 0.
- R2: A start condition is SDA falling while SCL is high. If the first byte after it carries bits [7:1] equal to own_addr, the block pulls SDA low during the 9th clock, sets busy, and sets rd_dir to bit 0 of that byte (1 = read).
- R3: If the address does not match, SDA is left released on the 9th clock and on every later clock until the next start or stop. No irq pulse occurs and SCL is never held.
- R4: On a match, the block holds SCL low (scl_oe = 1) from the falling edge of the 9th clock and raises irq for exactly one clk cycle.
- R5: In the read direction, a tx_wr pulse ends the stretch. A rel pulse alone leaves SCL held.
- R6: The byte on tx_data at the tx_wr pulse appears on SDA MSB first over the next 8 SCL clocks.
- R7: After each transmitted byte, the controller's bit on the 9th clock is sampled. ACK (0) causes a new stretch and a new irq pulse. NACK (1) releases SDA with no stretch and no irq, and SDA stays released until a stop or a start.
- R8: In the write direction, each received byte is acknowledged, stored on rx_data, and followed by a stretch with an irq pulse. A rel pulse ends that stretch. A tx_wr pulse alone has no effect on it.
- R9: A stop condition (SDA rising while SCL is high) clears busy. A start in any state, including in the middle of a byte, returns the block to waiting for an address.
- R10: The block changes its SDA drive only while SCL is low, so SDA stays constant during every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Address the target answers to |
| tx_data | input | 8 | Byte to transmit, taken at tx_wr |
| tx_wr | input | 1 | Transmit register write strobe |
| rel | input | 1 | Release strobe for write-direction stretch |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | One-cycle event pulse |
| busy | output | 1 | Addressed in the current transfer |
| rd_dir | output | 1 | 1 when the controller reads |
| rx_data | output | 8 | Last byte received |

## Verification
Software can assert tx_wr and rel in the same clk cycle, so the bench pulses both together during a read-direction hold and again during a write-direction hold. The first case must release SCL and transmit exactly the byte written with tx_wr. The second case must release SCL and then store the next received byte unchanged. Before each combined pulse, the bench applies the unrelated strobe by itself and confirms that scl_oe stays high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,  // no transfer for this target
    ST_ADDR,  // shifting in address byte
    ST_AACK,  // driving address ACK
    ST_HRX,   // write-direction hold, waiting for rel
    ST_RX,    // receiving data byte
    ST_RACK,  // driving data ACK
    ST_HTX,   // read-direction hold, waiting for tx_wr
    ST_TX,    // shifting out data byte
    ST_TACK,  // sampling controller ACK
    ST_WAIT   // ignore bus until stop or start
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              rel,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              busy,
  output logic              rd_dir,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  tgt_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              ackd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ackd    <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      irq     <= 1'b0;
      busy    <= 1'b0;
      rd_dir  <= 1'b0;
      rx_data <= '0;
    end else begin
      irq <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
      end else if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (sh[DATA_W-1:1] == own_addr) begin
                sda_oe <= 1'b1;
                busy   <= 1'b1;
                rd_dir <= sh[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              scl_oe <= 1'b1;
              irq    <= 1'b1;
              st     <= rd_dir ? ST_HTX : ST_HRX;
            end
          end
          ST_HRX: begin
            if (rel) begin
              scl_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              rx_data <= sh;
              sda_oe  <= 1'b1;
              st      <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              scl_oe <= 1'b1;
              irq    <= 1'b1;
              st     <= ST_HRX;
            end
          end
          ST_HTX: begin
            if (tx_wr) begin
              sh     <= tx_data;
              sda_oe <= ~tx_data[DATA_W-1];
              scl_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= ST_TACK;
              end else begin
                sh     <= {sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~sh[DATA_W-2];
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              ackd <= ~sda_s;
            end else if (scl_fall) begin
              if (ackd) begin
                scl_oe <= 1'b1;
                irq    <= 1'b1;
                st     <= ST_HTX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R10
  AST_STRETCH_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> irq); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R4
  AST_MATCH_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sda_oe); // R2
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_oe) && rd_dir && busy) |-> $past(tx_wr)); // R5
  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_oe) && !rd_dir && busy) |-> $past(rel)); // R8
  AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !busy) |-> (!scl_oe && !sda_oe)); // R3
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              rel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              busy,
  output logic              rd_dir,
  output logic [DATA_W-1:0] rx_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .own_addr  (own_addr),
    .tx_data   (tx_data),
    .tx_wr     (tx_wr),
    .rel       (rel),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq       (irq),
    .busy      (busy),
    .rd_dir    (rd_dir),
    .rx_data   (rx_data)
  );
endmodule

// File: tb/sim_i2c_target_stretch.sv
module sim_i2c_target_stretch;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WD_LIMIT   = 150000;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_wr = 1'b0;
  logic       rel = 1'b0;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic       scl_oe, sda_oe, irq, busy, rd_dir;
  logic [7:0] rx_data;
  wire        scl_line = ~(m_scl_low | scl_oe);
  wire        sda_line = ~(m_sda_low | sda_oe);

  int total = 0;
  int bad   = 0;
  int irq_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_stretch u0 (
    .clk(clk), .rst(rst), .own_addr(MY_ADDR), .tx_data(tx_data),
    .tx_wr(tx_wr), .rel(rel), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .busy(busy),
    .rd_dir(rd_dir), .rx_data(rx_data)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    for (int i = 0; i < 4000 && scl_line == 1'b0; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit do_tx, input bit do_rel, input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_wr = do_tx; rel = do_rel;
    @(negedge clk);
    tx_wr = 1'b0; rel = 1'b0;
    wait_clks(3);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wait_clks(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clks(Q);
    m_sda_low = 1'b1; wait_clks(Q);
    m_scl_low = 1'b1; wait_clks(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wait_clks(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clks(Q);
    m_sda_low = 1'b0; wait_clks(Q);
  endtask

  task automatic wr_bit(input bit b);
    m_sda_low = ~b; wait_clks(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clks(Q);
    m_scl_low = 1'b1; wait_clks(Q);
  endtask

  task automatic rd_bit(output bit b);
    logic s1;
    m_sda_low = 1'b0; wait_clks(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clks(2);
    s1 = sda_line; wait_clks(Q);
    chk(s1 == sda_line, "R10 sda stable while scl high", int'(sda_line), int'(s1));
    b = sda_line;
    m_scl_low = 1'b1; wait_clks(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack_n);
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(ack_n);
  endtask

  task automatic rd_byte(output logic [7:0] v, input bit ack_n);
    bit b;
    for (int i = 7; i >= 0; i--) begin rd_bit(b); v[i] = b; end
    wr_bit(ack_n);
  endtask

  task automatic t_reset();
    chk(scl_oe == 0 && sda_oe == 0, "R1 bus released", {scl_oe, sda_oe}, 0);
    chk(irq == 0 && busy == 0, "R1 irq/busy", {irq, busy}, 0);
  endtask

  task automatic t_mismatch();
    bit a; int ic;
    ic = irq_cnt;
    bus_start();
    wr_byte({7'h15, 1'b0}, a);
    chk(a == 1, "R3 nack on mismatch", a, 1);
    chk(scl_oe == 0, "R3 no stretch", scl_oe, 0);
    wr_byte(8'h00, a);
    chk(a == 1, "R3 later byte not acked", a, 1);
    chk(irq_cnt == ic && busy == 0, "R3 no irq", irq_cnt - ic, 0);
    bus_stop();
  endtask

  task automatic t_write();
    bit a; int ic;
    ic = irq_cnt;
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a);
    chk(a == 0, "R2 address ack", a, 0);
    chk(busy == 1 && rd_dir == 0, "R2 busy/dir", {busy, rd_dir}, 2);
    chk(scl_oe == 1, "R4 stretch after match", scl_oe, 1);
    chk(irq_cnt == ic + 1, "R4 one irq", irq_cnt - ic, 1);
    pulse(1'b1, 1'b0, 8'hFF);
    chk(scl_oe == 1, "R8 tx_wr ignored in write hold", scl_oe, 1);
    pulse(1'b0, 1'b1, 8'h00);
    chk(scl_oe == 0, "R8 rel releases", scl_oe, 0);
    wr_byte(8'hA5, a);
    chk(a == 0 && rx_data == 8'hA5, "R8 byte acked/stored", rx_data, 8'hA5);
    chk(scl_oe == 1 && irq_cnt == ic + 2, "R8 stretch+irq after byte", irq_cnt - ic, 2);
    pulse(1'b1, 1'b1, 8'h11);
    chk(scl_oe == 0, "R8 same-cycle tx_wr+rel releases", scl_oe, 0);
    wr_byte(8'h5A, a);
    chk(a == 0 && rx_data == 8'h5A, "R8 second byte", rx_data, 8'h5A);
    pulse(1'b0, 1'b1, 8'h00);
    bus_stop();
    chk(busy == 0, "R9 stop clears busy", busy, 0);
  endtask

  task automatic t_read();
    bit a; int ic; logic [7:0] v;
    ic = irq_cnt;
    bus_start();
    wr_byte({MY_ADDR, 1'b1}, a);
    chk(a == 0 && rd_dir == 1, "R2 read ack/dir", {a, rd_dir}, 1);
    chk(scl_oe == 1 && irq_cnt == ic + 1, "R4 read stretch+irq", irq_cnt - ic, 1);
    pulse(1'b0, 1'b1, 8'h00);
    chk(scl_oe == 1, "R5 rel ignored in read hold", scl_oe, 1);
    pulse(1'b1, 1'b1, 8'h3C);
    chk(scl_oe == 0, "R5 tx_wr releases", scl_oe, 0);
    rd_byte(v, 1'b0);
    chk(v == 8'h3C, "R6 byte shifted msb first", v, 8'h3C);
    chk(scl_oe == 1 && irq_cnt == ic + 2, "R7 ack -> stretch+irq", irq_cnt - ic, 2);
    pulse(1'b1, 1'b0, 8'hC3);
    rd_byte(v, 1'b1);
    chk(v == 8'hC3, "R6 second byte", v, 8'hC3);
    chk(scl_oe == 0 && sda_oe == 0, "R7 nack releases", {scl_oe, sda_oe}, 0);
    chk(irq_cnt == ic + 2, "R7 no irq on nack", irq_cnt - ic, 2);
    rd_bit(a);
    chk(a == 1, "R7 sda released after nack", a, 1);
    bus_stop();
    chk(busy == 0, "R9 stop after read", busy, 0);
  endtask

  task automatic t_restart();
    bit a; logic [7:0] v;
    bus_start();
    wr_byte({MY_ADDR, 1'b0}, a);
    pulse(1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 4; i++) wr_bit(i[0]);
    bus_start();
    wr_byte({MY_ADDR, 1'b1}, a);
    chk(a == 0 && rd_dir == 1, "R9 repeated start mid-byte", {a, rd_dir}, 1);
    pulse(1'b1, 1'b0, 8'h96);
    rd_byte(v, 1'b1);
    chk(v == 8'h96, "R6 byte after restart", v, 8'h96);
    bus_stop();
  endtask

  initial begin
    wait_clks(4);
    rst = 1'b0;
    wait_clks(4);
    t_reset();
    t_mismatch();
    t_write();
    t_read();
    t_restart();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule